// File: doc/BRIEF.md
# Byte-Wide GPIO Port Controller with Change Interrupt

This block is the register and interrupt core of an eight-pin general purpose I/O port. A host agent, normally a serial-bus slave front end, reaches four byte-wide registers through a small synchronous access port. The port has a 2-bit register index, a write strobe with write data, and a read strobe with registered read data. The registers are the sampled pin levels, the output drive values, a per-bit read inversion mask and a per-bit direction mask. The block drives an output enable and a data value for each pin. It samples each pin level through a two-flop synchronizer.

The block watches every pin set as an input. It compares the level of that pin with a snapshot that is taken each time the host reads the pin register. While any such pin differs from its snapshot, the block raises an open-drain interrupt enable. That enable is high when the active-low interrupt line should be pulled low. The interrupt clears in two ways: the pins return to their snapshot levels, or the host reads the pin register, which refreshes the snapshot.

Top module: `gpio_xp_core`

## Requirements
- R1: While rst_ni is low and after it rises, the drive register reads 0xFF, the inversion mask reads 0x00 and the direction mask reads 0xFF. In this state pin_oe_o is 0x00, pin_do_o is 0x00 and irq_od_o is 0.
- R2: A write strobe with index 1 (drive), 2 (inversion) or 3 (direction) stores wr_data_i at that clock edge. A read strobe puts the selected register on rd_data_o after the same edge.
- R3: A write strobe with index 0 (pin register) changes no register.
- R4: A direction bit of 1 makes the pin an input: pin_oe_o is 0 for that bit and pin_do_o is 0. A direction bit of 0 makes the pin an output: pin_oe_o is 1 and pin_do_o carries the drive register bit.
- R5: A read of index 1 returns the stored drive value and never the pin level.
- R6: A read of index 0 returns each synchronized pin level XORed with its inversion bit, for every pin whatever its direction. A pin change is visible two clock edges after it occurs.
- R7: irq_od_o is 1 while some input-direction pin's synchronized level differs from the snapshot.
- R8: irq_od_o returns to 0 when the differing pins return to their snapshot levels.
- R9: A read of index 0 loads the synchronized levels into the snapshot. From the next cycle, irq_od_o is 0 if the pins stay steady.
- R10: Output-direction pins never raise the interrupt. Turning such a pin into an input raises irq_od_o when its level differs from the snapshot.
- R11: rd_data_o holds its value in cycles without a read strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low reset |
| idx_i | input | 2 | Register index for reads and writes |
| wr_en_i | input | 1 | Write strobe |
| wr_data_i | input | 8 | Write data |
| rd_en_i | input | 1 | Read strobe |
| rd_data_o | output | 8 | Registered read data |
| pin_i | input | 8 | Sampled pin levels |
| pin_oe_o | output | 8 | Per-pin output enable |
| pin_do_o | output | 8 | Per-pin output data |
| irq_od_o | output | 1 | High when the interrupt line should be pulled low |

## Verification
A corrupted snapshot is the hardest fault to see. It shows up only as a wrong irq_od_o level, and only once pins set as inputs sit at a level that exposes it. For that reason the bench checks the interrupt both before and after a read refreshes the snapshot. A wrong direction or drive bit reaches pin_oe_o and pin_do_o one cycle after the write. A wrong inversion bit is caught on the next read of the pin register. A stuck synchronizer stage shows as a missing or late change, so pin effects are sampled exactly two edges after the stimulus.

// File: rtl/gpio_xp_pkg.sv
package gpio_xp_pkg;
  localparam int unsigned IDX_W = 2;
  typedef enum logic [IDX_W-1:0] {
    IDX_PIN = 2'd0,
    IDX_DRV = 2'd1,
    IDX_INV = 2'd2,
    IDX_DIR = 2'd3
  } reg_idx_e;
endpackage

// File: rtl/gpio_xp_sync.sv
module gpio_xp_sync #(
  parameter int unsigned WIDTH  = 8,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [STAGES-1:0][WIDTH-1:0] chain_q;

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) chain_q[s] <= '0;
      else if (s == 0) chain_q[s] <= d_i;
      else chain_q[s] <= chain_q[(s == 0) ? 0 : s-1];
    end
  end

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/gpio_xp_regs.sv
module gpio_xp_regs
  import gpio_xp_pkg::*;
#(
  parameter int unsigned WIDTH = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  reg_idx_e         idx_i,
  input  logic [WIDTH-1:0] wr_data_i,
  output logic [WIDTH-1:0] drv_o,
  output logic [WIDTH-1:0] inv_o,
  output logic [WIDTH-1:0] dir_o
);
  logic [WIDTH-1:0] drv_q, inv_q, dir_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      drv_q <= '1;
      inv_q <= '0;
      dir_q <= '1;
    end else if (wr_en_i) begin
      unique case (idx_i)
        IDX_DRV: drv_q <= wr_data_i;
        IDX_INV: inv_q <= wr_data_i;
        IDX_DIR: dir_q <= wr_data_i;
        default: ; // pin register is read-only
      endcase
    end
  end

  assign drv_o = drv_q;
  assign inv_o = inv_q;
  assign dir_o = dir_q;

  a_r3_pin_write_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && idx_i == IDX_PIN) |=> ($stable(drv_q) && $stable(inv_q) && $stable(dir_q)));

  a_r2_drv_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && idx_i == IDX_DRV) |=> (drv_q == $past(wr_data_i)));
endmodule

// File: rtl/gpio_xp_irq.sv
module gpio_xp_irq #(
  parameter int unsigned WIDTH = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] lvl_i,
  input  logic [WIDTH-1:0] dir_i,
  input  logic             snap_i,
  output logic             irq_o
);
  logic [WIDTH-1:0] snap_q;
  logic [WIDTH-1:0] diff;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) snap_q <= '0;
    else if (snap_i) snap_q <= lvl_i;
  end

  // only pins set as inputs take part in the compare
  assign diff  = (lvl_i ^ snap_q) & dir_i;
  assign irq_o = |diff;

  a_r9_snap_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    snap_i |=> (!$stable(lvl_i) || !irq_o));
endmodule

// File: rtl/gpio_xp_core.sv
module gpio_xp_core
  import gpio_xp_pkg::*;
#(
  parameter int unsigned WIDTH = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [IDX_W-1:0] idx_i,
  input  logic             wr_en_i,
  input  logic [WIDTH-1:0] wr_data_i,
  input  logic             rd_en_i,
  output logic [WIDTH-1:0] rd_data_o,
  input  logic [WIDTH-1:0] pin_i,
  output logic [WIDTH-1:0] pin_oe_o,
  output logic [WIDTH-1:0] pin_do_o,
  output logic             irq_od_o
);
  reg_idx_e         idx;
  logic [WIDTH-1:0] lvl, drv, inv, dir;
  logic [WIDTH-1:0] rd_q;
  logic             snap;

  assign idx = reg_idx_e'(idx_i);

  gpio_xp_sync #(.WIDTH(WIDTH), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (pin_i),
    .q_o   (lvl)
  );

  gpio_xp_regs #(.WIDTH(WIDTH)) u_regs (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_en_i  (wr_en_i),
    .idx_i    (idx),
    .wr_data_i(wr_data_i),
    .drv_o    (drv),
    .inv_o    (inv),
    .dir_o    (dir)
  );

  assign snap = rd_en_i && (idx == IDX_PIN);

  gpio_xp_irq #(.WIDTH(WIDTH)) u_irq (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .lvl_i (lvl),
    .dir_i (dir),
    .snap_i(snap),
    .irq_o (irq_od_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rd_q <= '0;
    else if (rd_en_i) begin
      unique case (idx)
        IDX_PIN: rd_q <= lvl ^ inv;
        IDX_DRV: rd_q <= drv;
        IDX_INV: rd_q <= inv;
        IDX_DIR: rd_q <= dir;
        default: rd_q <= '0;
      endcase
    end
  end

  assign rd_data_o = rd_q;
  assign pin_oe_o  = ~dir;
  assign pin_do_o  = drv & ~dir;

  a_r11_rd_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_en_i |=> $stable(rd_data_o));

  a_r4_dir_write_oe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && idx == IDX_DIR) |=> (pin_oe_o == ~$past(wr_data_i)));

  a_r5_drv_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && idx == IDX_DRV && !wr_en_i) |=> (rd_data_o == (pin_do_o | (drv & ~pin_oe_o))));
endmodule

// File: tb/tb_gpio_xp_core.sv
module tb_gpio_xp_core;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [1:0] idx_i = '0;
  logic       wr_en_i = 1'b0;
  logic [7:0] wr_data_i = '0;
  logic       rd_en_i = 1'b0;
  logic [7:0] rd_data_o;
  logic [7:0] pin_i = '0;
  logic [7:0] pin_oe_o;
  logic [7:0] pin_do_o;
  logic       irq_od_o;

  int checks = 0;
  int errors = 0;

  always #10 clk_i = ~clk_i;

  gpio_xp_core dut (
    .clk_i, .rst_ni, .idx_i, .wr_en_i, .wr_data_i, .rd_en_i,
    .rd_data_o, .pin_i, .pin_oe_o, .pin_do_o, .irq_od_o
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] idx, input logic [7:0] d);
    @(negedge clk_i);
    idx_i = idx; wr_data_i = d; wr_en_i = 1'b1;
    @(negedge clk_i);
    wr_en_i = 1'b0;
  endtask

  task automatic rd(input logic [1:0] idx, output logic [7:0] d);
    @(negedge clk_i);
    idx_i = idx; rd_en_i = 1'b1;
    @(negedge clk_i);
    rd_en_i = 1'b0;
    d = rd_data_o;
  endtask

  task automatic set_pins(input logic [7:0] p);
    @(negedge clk_i);
    pin_i = p;
    repeat (2) @(negedge clk_i);
  endtask

  task automatic t_reset;
    logic [7:0] d;
    chk("R1 oe", pin_oe_o, 8'h00);
    chk("R1 do", pin_do_o, 8'h00);
    chk("R1 irq", {7'b0, irq_od_o}, 8'h00);
    rd(2'd1, d); chk("R1 drv", d, 8'hFF);
    rd(2'd2, d); chk("R1 inv", d, 8'h00);
    rd(2'd3, d); chk("R1 dir", d, 8'hFF);
  endtask

  task automatic t_rw;
    logic [7:0] d;
    wr(2'd1, 8'hA5); wr(2'd2, 8'h3C); wr(2'd3, 8'h0F);
    rd(2'd1, d); chk("R2 drv", d, 8'hA5);
    rd(2'd2, d); chk("R2 inv", d, 8'h3C);
    rd(2'd3, d); chk("R2 dir", d, 8'h0F);
    chk("R4 oe", pin_oe_o, 8'hF0);
    chk("R4 do", pin_do_o, 8'hA0);
  endtask

  task automatic t_pin_write;
    logic [7:0] d;
    wr(2'd0, 8'h55);
    rd(2'd1, d); chk("R3 drv", d, 8'hA5);
    rd(2'd2, d); chk("R3 inv", d, 8'h3C);
    rd(2'd3, d); chk("R3 dir", d, 8'h0F);
  endtask

  task automatic t_drv_read;
    logic [7:0] d;
    set_pins(8'h0F);
    rd(2'd1, d); chk("R5 drv not pin", d, 8'hA5);
  endtask

  task automatic t_pin_read;
    logic [7:0] d;
    set_pins(8'h96);
    rd(2'd0, d); chk("R6 inverted read", d, 8'hAA);
    // one edge only: synchronizer still holds old level 0x96
    @(negedge clk_i); pin_i = 8'h00;
    idx_i = 2'd0; rd_en_i = 1'b1;
    @(negedge clk_i); rd_en_i = 1'b0;
    chk("R6 sync latency", rd_data_o, 8'hAA);
    @(negedge clk_i);
    rd(2'd0, d); chk("R6 after two edges", d, 8'h3C);
  endtask

  task automatic t_irq;
    logic [7:0] d;
    wr(2'd2, 8'h00); wr(2'd3, 8'hFF);
    set_pins(8'h00);
    rd(2'd0, d);
    chk("R9 irq idle", {7'b0, irq_od_o}, 8'h00);
    set_pins(8'h10);
    chk("R7 irq set", {7'b0, irq_od_o}, 8'h01);
    set_pins(8'h00);
    chk("R8 irq back", {7'b0, irq_od_o}, 8'h00);
    set_pins(8'h10);
    chk("R7 irq set again", {7'b0, irq_od_o}, 8'h01);
    rd(2'd0, d);
    chk("R9 read data", d, 8'h10);
    chk("R9 irq cleared", {7'b0, irq_od_o}, 8'h00);
  endtask

  task automatic t_dir_switch;
    logic [7:0] d;
    set_pins(8'h00);
    rd(2'd0, d);
    wr(2'd3, 8'hFE);
    set_pins(8'h01);
    chk("R10 output pin no irq", {7'b0, irq_od_o}, 8'h00);
    wr(2'd3, 8'hFF);
    chk("R10 switch raises irq", {7'b0, irq_od_o}, 8'h01);
  endtask

  task automatic t_hold;
    logic [7:0] d;
    rd(2'd3, d);
    wr(2'd3, 8'h12);
    set_pins(8'hC3);
    chk("R11 hold", rd_data_o, 8'hFF);
  endtask

  task automatic t_reset_hold;
    @(negedge clk_i); rst_ni = 1'b0;
    wr(2'd1, 8'h00);
    chk("R1 held oe", pin_oe_o, 8'h00);
    chk("R1 held rd", rd_data_o, 8'h00);
    @(negedge clk_i); rst_ni = 1'b1;
    chk("R1 held irq", {7'b0, irq_od_o}, 8'h00);
  endtask

  initial begin
    #200000;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    t_reset();
    t_rw();
    t_pin_write();
    t_drv_read();
    t_pin_read();
    t_irq();
    t_dir_switch();
    t_hold();
    t_reset_hold();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule